// File: doc/BRIEF.md
# Multichannel SAR converter sequencing controller

This block is the host side of a link to a multichannel successive-approximation converter. The link is a 4-wire serial port (SPI mode 0, MSB first) plus two extra strobes: an active-low start strobe driven by this block and an active-low conversion-done flag driven by the converter. When `start` is pulsed, the block takes a copy of the requested trigger discipline, the highest channel to scan and the averaging setting. It then sends four single-byte frames: a FIFO flush, the setup byte, the averaging byte and the conversion byte.

Next it launches sampling in one of three ways. Mode 0 uses a single start pulse for the whole series. Mode 1 uses one start pulse per acquisition. Mode 2 has no start pulse: the chip-select release after the conversion byte starts the series. The block then waits for the done flag. Once the flag arrives, it reads one 16-bit result per channel, from channel 0 upward, and presents each result with a one-cycle valid strobe.

If the done flag never arrives, a cycle-count timeout ends the series with a one-cycle error strobe. The serial clock runs at half the system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held and after it is released, `cs_n` and `cnvst_n` are high and `sclk`, `busy`, `err` and `res_valid` are low.
- R2: A series sends four 8-bit frames. Each frame has its own chip-select low period, and `mosi` is stable at each `sclk` rising edge. The frames, in order, are: 0x18 (FIFO flush); setup = {01, mode[1:0], 10, 00}; averaging = {001, avg_en, avg_code[1:0], 00}; conversion = {1, 0, chan_last[2:0], 000}.
- R3: In mode 0, after the conversion byte, exactly one `cnvst_n` low pulse of PULSE_SINGLE clock cycles is issued.
- R4: In mode 1, the number of `cnvst_n` pulses is N×(chan_last+1), each PULSE_EACH cycles long. N is 1 with averaging off, and 4, 8, 16 or 32 for avg_code 00, 01, 10 or 11. A pulse is never issued until `eoc_n` has gone low for the previous one.
- R5: In mode 2, no `cnvst_n` pulse is issued. The series is launched by the chip-select rise that ends the conversion byte.
- R6: Readback begins only after `eoc_n` is low. It consists of chan_last+1 frames of 16 bits, with `miso` sampled on `sclk` rising, MSB first. Each frame produces one single-cycle `res_valid` carrying `res_data` and `res_chan`, with channels ascending from 0.
- R7: `start` has no effect while `busy` is high.
- R8: A start request with mode 11 is refused. `err` goes high for one cycle, no frame is sent and `busy` stays low.
- R9: If `eoc_n` stays high for TIMEOUT_CYC cycles while the block is waiting, `err` pulses for one cycle and the block returns to idle with both strobes high. No result is produced, and the next series works normally.
- R10: `cnvst_n` and `cs_n` are never low together, and `sclk` is low whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle series request |
| mode | input | 2 | Trigger discipline: 0 single pulse, 1 pulse per sample, 2 chip-select launch |
| chan_last | input | 3 | Highest channel of the scan (scan is 0..chan_last) |
| avg_en | input | 1 | Averaging enable |
| avg_code | input | 2 | Averaging depth code |
| miso | input | 1 | Serial data from converter |
| eoc_n | input | 1 | Active-low conversion-done flag |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to converter |
| cnvst_n | output | 1 | Active-low start strobe |
| busy | output | 1 | Series in progress |
| err | output | 1 | One-cycle refusal or timeout strobe |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Result word |
| res_chan | output | 3 | Channel of the result |

## Verification
The hardest behaviour to reach is the per-sample pulse discipline of mode 1. To exercise it, the converter model in the bench reacts to every strobe edge. It holds the done flag high from each start fall until a fixed delay after the following start rise, and it counts any pulse that begins before the flag has fallen. Runs with 32 pulses force the controller through that handshake dozens of times in a row. The timeout path is reached by turning off the model's done flag, and a restart request is injected in the middle of a running series.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int PULSE_SINGLE = 2,
  parameter int PULSE_EACH   = 4,
  parameter int TIMEOUT_CYC  = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic [2:0]  chan_last,
  input  logic        avg_en,
  input  logic [1:0]  avg_code,
  input  logic        miso,
  input  logic        eoc_n,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  output logic        cnvst_n,
  output logic        busy,
  output logic        err,
  output logic        res_valid,
  output logic [15:0] res_data,
  output logic [2:0]  res_chan
);
  localparam int TW = $clog2(TIMEOUT_CYC + PULSE_SINGLE + PULSE_EACH + 1);

  typedef enum logic [2:0] {S_IDLE, S_XFER, S_GAP, S_TRIG, S_WAIT} st_t;

  st_t         st;
  logic        ph, len16;
  logic [3:0]  bcnt;
  logic [2:0]  step, rdch, cl;
  logic [15:0] tx, rx;
  logic [1:0]  md, ac;
  logic        ae;
  logic [8:0]  pcnt;
  logic [TW-1:0] tcnt;

  logic [7:0] setup_b, avg_b, conv_b;
  logic [8:0] nsamp, npulse;
  logic [TW-1:0] pw_last;

  assign setup_b = {2'b01, md, 2'b10, 2'b00};
  assign avg_b   = {3'b001, ae, ac, 2'b00};
  assign conv_b  = {1'b1, 1'b0, cl, 3'b000};
  assign nsamp   = ae ? (9'd4 << ac) : 9'd1;
  assign npulse  = nsamp * ({6'd0, cl} + 9'd1);
  assign pw_last = (md == 2'd1) ? TW'(PULSE_EACH - 1) : TW'(PULSE_SINGLE - 1);

  assign busy    = (st != S_IDLE);
  assign cs_n    = (st != S_XFER);
  assign sclk    = (st == S_XFER) & ph;
  assign mosi    = (st == S_XFER) & tx[15];
  assign cnvst_n = (st != S_TRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; len16 <= 1'b0; bcnt <= '0; step <= '0;
      rdch <= '0; cl <= '0; tx <= '0; rx <= '0; md <= '0; ac <= '0;
      ae <= 1'b0; pcnt <= '0; tcnt <= '0; err <= 1'b0;
      res_valid <= 1'b0; res_data <= '0; res_chan <= '0;
    end else begin
      res_valid <= 1'b0;
      err       <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (mode == 2'b11) err <= 1'b1;
          else begin
            md <= mode; cl <= chan_last; ae <= avg_en; ac <= avg_code;
            step <= 3'd0; tx <= {8'h18, 8'h00}; len16 <= 1'b0;
            bcnt <= '0; ph <= 1'b0; st <= S_XFER;
          end
        end
        S_XFER: begin
          if (!ph) ph <= 1'b1;
          else begin
            ph <= 1'b0;
            rx <= {rx[14:0], miso};
            tx <= {tx[14:0], 1'b0};
            if (bcnt == {len16, 3'b111}) st <= S_GAP;
            else bcnt <= bcnt + 4'd1;
          end
        end
        S_GAP: begin
          bcnt <= '0; ph <= 1'b0; tcnt <= '0;
          case (step)
            3'd0: begin step <= 3'd1; tx <= {setup_b, 8'h00}; st <= S_XFER; end
            3'd1: begin step <= 3'd2; tx <= {avg_b, 8'h00};   st <= S_XFER; end
            3'd2: begin step <= 3'd3; tx <= {conv_b, 8'h00};  st <= S_XFER; end
            3'd3: begin
              step <= 3'd4; rdch <= '0; pcnt <= npulse - 9'd1;
              st <= (md == 2'd2) ? S_WAIT : S_TRIG;
            end
            default: begin
              res_valid <= 1'b1; res_data <= rx; res_chan <= rdch;
              if (rdch == cl) st <= S_IDLE;
              else begin rdch <= rdch + 3'd1; tx <= '0; st <= S_XFER; end
            end
          endcase
        end
        S_TRIG: begin
          if (tcnt == pw_last) begin tcnt <= '0; st <= S_WAIT; end
          else tcnt <= tcnt + 1'b1;
        end
        S_WAIT: begin
          if (!eoc_n) begin
            tcnt <= '0;
            if (md == 2'd1 && pcnt != 9'd0) begin pcnt <= pcnt - 9'd1; st <= S_TRIG; end
            else begin tx <= '0; len16 <= 1'b1; bcnt <= '0; ph <= 1'b0; st <= S_XFER; end
          end else if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
            err <= 1'b1; st <= S_IDLE;
          end else tcnt <= tcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] mode,
  input logic       busy,
  input logic       err,
  input logic       cs_n,
  input logic       cnvst_n,
  input logic       sclk,
  input logic       res_valid
);
  AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(!cs_n && !cnvst_n)); // R10
  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R10
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R6
  AST_ERR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!busy && cs_n && cnvst_n)); // R9
  AST_CNV_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(cnvst_n) |=> !cnvst_n); // R3
  AST_MODE3_REFUSED: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && mode == 2'b11) |=> (err && !busy && cs_n)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (start && busy && !cs_n) |=> !err); // R7
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy), .err(err),
  .cs_n(cs_n), .cnvst_n(cnvst_n), .sclk(sclk), .res_valid(res_valid)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P_SINGLE = 2;
  localparam int P_EACH = 4;
  localparam int T_OUT = 300;
  localparam int EOC_DLY = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, avg_en = 1'b0, eoc_en = 1'b1;
  logic [1:0] mode = '0, avg_code = '0;
  logic [2:0] chan_last = '0;
  logic miso, eoc_n, sclk, cs_n, mosi, cnvst_n, busy, err, res_valid;
  logic [15:0] res_data;
  logic [2:0] res_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.PULSE_SINGLE(P_SINGLE), .PULSE_EACH(P_EACH), .TIMEOUT_CYC(T_OUT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .chan_last(chan_last),
    .avg_en(avg_en), .avg_code(avg_code), .miso(miso), .eoc_n(eoc_n),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .cnvst_n(cnvst_n), .busy(busy), .err(err),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan));

  // converter model
  logic pcs = 1'b1, psclk = 1'b0, pcnv = 1'b1, eoc_r = 1'b1, eoc_seen = 1'b0, pulse_ok = 1'b0;
  logic [15:0] sh = '0;
  logic [4:0] bitc = '0;
  logic [7:0] ser = '0;
  logic [7:0] mb [4];
  int nb = 0, npulse = 0, wmin = 0, wmax = 0, lw = 0, viol = 0, early = 0, tmr = 0, csfalls = 0;
  logic [2:0] rdidx = '0;
  logic [15:0] rword;

  assign rword = 16'hC000 | {4'h0, ser, 4'h0} | {13'd0, rdidx};
  assign miso = rword[4'd15 - bitc[3:0]];
  assign eoc_n = eoc_r;

  always @(posedge clk) begin
    pcs <= cs_n; psclk <= sclk; pcnv <= cnvst_n;
    if (tmr > 0) begin
      tmr <= tmr - 1;
      if (tmr == 1 && eoc_en) begin eoc_r <= 1'b0; eoc_seen <= 1'b1; pulse_ok <= 1'b1; end
    end
    if (pcs && !cs_n) begin bitc <= '0; sh <= '0; eoc_r <= 1'b1; csfalls <= csfalls + 1; end
    if (!cs_n && !psclk && sclk) begin sh <= {sh[14:0], mosi}; bitc <= bitc + 5'd1; end
    if (!pcs && cs_n) begin
      if (bitc == 5'd8) begin
        if (sh[7:0] == 8'h18) begin
          ser <= ser + 8'd1; nb <= 1; mb[0] <= sh[7:0]; npulse <= 0; wmin <= 9999; wmax <= 0;
          viol <= 0; early <= 0; eoc_seen <= 1'b0; rdidx <= '0; pulse_ok <= 1'b0;
        end else begin
          if (nb < 4) mb[nb[1:0]] <= sh[7:0];
          nb <= nb + 1;
          if (nb == 3 && mb[1][5:4] == 2'd2) tmr <= EOC_DLY;
        end
      end else if (bitc == 5'd16) begin
        if (!eoc_seen) early <= early + 1;
        rdidx <= rdidx + 3'd1;
      end
    end
    if (pcnv && !cnvst_n) begin
      lw <= 1; eoc_r <= 1'b1;
      if (npulse > 0 && !pulse_ok) viol <= viol + 1;
      pulse_ok <= 1'b0;
    end else if (!pcnv && !cnvst_n) lw <= lw + 1;
    if (!pcnv && cnvst_n) begin
      npulse <= npulse + 1; tmr <= EOC_DLY;
      if (lw < wmin) wmin <= lw;
      if (lw > wmax) wmax <= lw;
    end
  end

  // result monitor
  int res_total = 0, res_bad = 0, errs = 0, mon_idx = 0, bad_act = 0, bad_exp = 0;
  logic [7:0] last_ser = '0;
  always @(negedge clk) begin
    if (err) errs = errs + 1;
    if (res_valid) begin
      if (ser != last_ser) begin mon_idx = 0; last_ser = ser; end
      if (res_chan != mon_idx[2:0] ||
          res_data != (16'hC000 | {4'h0, ser, 4'h0} | {13'd0, mon_idx[2:0]})) begin
        res_bad = res_bad + 1; bad_act = {13'd0, res_chan} * 65536 + res_data; bad_exp = mon_idx;
      end
      mon_idx = mon_idx + 1;
      res_total = res_total + 1;
    end
  end

  int ntests = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    int cyc = 0;
    while (busy && cyc < 40000) begin @(negedge clk); cyc++; end
    @(negedge clk);
  endtask

  task automatic run_series(input logic [1:0] m, input logic [2:0] c, input logic e, input logic [1:0] a);
    int s0, r0, b0, e0, ns, expp;
    s0 = ser; r0 = res_total; b0 = res_bad; e0 = errs;
    @(negedge clk);
    mode = m; chan_last = c; avg_en = e; avg_code = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    ns = e ? (4 << a) : 1;
    chk(ser == s0 + 1, "R2", "flush frames", ser, s0 + 1);
    chk(nb == 4, "R2", "config frame count", nb, 4);
    chk(mb[1] == {2'b01, m, 4'b1000}, "R2", "setup byte", mb[1], {2'b01, m, 4'b1000});
    chk(mb[2] == {3'b001, e, a, 2'b00}, "R2", "averaging byte", mb[2], {3'b001, e, a, 2'b00});
    chk(mb[3] == {2'b10, c, 3'b000}, "R2", "conversion byte", mb[3], {2'b10, c, 3'b000});
    if (m == 2'd0) begin
      chk(npulse == 1, "R3", "pulse count", npulse, 1);
      chk(wmin == P_SINGLE && wmax == P_SINGLE, "R3", "pulse width", wmax, P_SINGLE);
    end else if (m == 2'd1) begin
      expp = ns * (c + 1);
      chk(npulse == expp, "R4", "pulse count", npulse, expp);
      chk(wmin == P_EACH && wmax == P_EACH, "R4", "pulse width", wmin, P_EACH);
      chk(viol == 0, "R4", "pulse before done flag", viol, 0);
    end else begin
      chk(npulse == 0, "R5", "pulse count", npulse, 0);
    end
    chk(res_total - r0 == c + 1, "R6", "result count", res_total - r0, c + 1);
    chk(res_bad == b0, "R6", "result chan/data", bad_act, bad_exp);
    chk(early == 0, "R6", "read before done", early, 0);
    chk(errs == e0, "R9", "no error on normal run", errs - e0, 0);
  endtask

  localparam logic [7:0] VEC [8] = '{
    {2'd0, 3'd0, 1'b0, 2'd0},
    {2'd0, 3'd3, 1'b1, 2'd3},
    {2'd1, 3'd0, 1'b1, 2'd0},
    {2'd1, 3'd3, 1'b1, 2'd1},
    {2'd2, 3'd3, 1'b1, 2'd3},
    {2'd1, 3'd1, 1'b1, 2'd2},
    {2'd2, 3'd7, 1'b0, 2'd0},
    {2'd1, 3'd2, 1'b0, 2'd0}
  };

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      nfail++; ntests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    int s0, r0, e0, c0;
    repeat (3) @(negedge clk);
    chk(cs_n && cnvst_n && !sclk && !busy && !err && !res_valid, "R1", "lines in reset",
        {cs_n, cnvst_n, sclk, busy, err, res_valid}, 6'b110000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && cnvst_n && !sclk && !busy && !res_valid, "R1", "lines after reset",
        {cs_n, cnvst_n, sclk, busy, res_valid}, 5'b11000);

    for (int i = 0; i < 8; i++)
      run_series(VEC[i][7:6], VEC[i][5:3], VEC[i][2], VEC[i][1:0]);

    // R7: restart request in the middle of a series
    s0 = ser; r0 = res_total;
    @(negedge clk);
    mode = 2'd1; chan_last = 3'd1; avg_en = 1'b1; avg_code = 2'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    mode = 2'd0; chan_last = 3'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();
    chk(ser == s0 + 1, "R7", "series count", ser, s0 + 1);
    chk(npulse == 8, "R7", "pulses of first request", npulse, 8);
    chk(res_total - r0 == 2, "R7", "results of first request", res_total - r0, 2);

    // R8: mode 11 refused
    c0 = csfalls; e0 = errs;
    @(negedge clk); mode = 2'b11; chan_last = 3'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err && !busy, "R8", "refusal strobe", {err, busy}, 2'b10);
    @(negedge clk);
    chk(!err, "R8", "strobe one cycle", err, 0);
    repeat (10) @(negedge clk);
    chk(csfalls == c0 && !busy, "R8", "no frame sent", csfalls - c0, 0);

    // R9: done flag never comes
    eoc_en = 1'b0; r0 = res_total; e0 = errs;
    @(negedge clk); mode = 2'd0; chan_last = 3'd1; avg_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();
    chk(errs - e0 == 1, "R9", "timeout strobe count", errs - e0, 1);
    chk(res_total == r0, "R9", "no result on timeout", res_total - r0, 0);
    chk(cs_n && cnvst_n && !busy, "R9", "lines released", {cs_n, cnvst_n, busy}, 3'b110);
    eoc_en = 1'b1;
    run_series(2'd2, 3'd2, 1'b1, 2'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule